// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block serves one processor core with two machine-level interrupt sources: a software interrupt that the core raises or clears by writing a register, and a timer interrupt driven by comparing a free-running 64-bit time base against a 64-bit deadline register. The core reaches the block through a small register port. Each request carries an address, a size code, a read/write flag and write data. The response, either read data or an access fault, comes back combinationally in the same cycle.

The register map is sparse and fixed. Each offset accepts only certain access sizes. Any request outside those pairs is refused with a fault, and the fault leaves every register as it was. The time base does not count clock cycles. It advances by one after a parameterised number of tick pulses from the core, so software sees time at a fixed fraction of the tick rate.

Top module: `core_timer_unit`

## Requirements
- R1: After reset, the time base reads 0, the deadline register reads all ones, and both interrupt outputs are low.
- R2: A write at offset 0x0000 with size code 2 (4 bytes) or 3 (8 bytes) sets the software pending bit to bit 0 of the write data. `irq_soft_o` shows the pending bit from the next cycle.
- R3: A read at offset 0x0000 with size code 2 or 3 returns the pending bit in data bit 0, and every other data bit is 0.
- R4: The deadline register can be read and written as a full 64-bit value at 0x4000 with size code 3. With size code 2, its lower half is at 0x4000 and its upper half at 0x4004, carried in data bits 31:0. A half-word read returns zeros in bits 63:32.
- R5: The time base is read-only. It reads as a full 64-bit value at 0xBFF8 with size code 3. With size code 2, its lower half is at 0xBFF8 and its upper half at 0xBFFC. Any write to these offsets faults.
- R6: The time base increases by exactly one after every TICKS_PER_INC pulses of `tick_i`. Cycles with `tick_i` low do not count toward that total.
- R7: `irq_timer_o` is high exactly when the time base is greater than or equal to the deadline register. Writing a larger deadline lowers it in the cycle after the write.
- R8: Any request outside the pairs listed in R2 to R5 asserts `rsp_fault_o` in the same cycle and returns zero data. This includes size codes 0 and 1, any other offset, and an 8-byte access at 0x4004 or 0xBFFC. A faulting request changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time base tick pulse from the core |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the request |
| req_size_i | input | 2 | Log2 of the access size in bytes |
| req_wdata_i | input | 64 | Write data |
| rsp_rdata_o | output | 64 | Read data, zero on writes and faults |
| rsp_fault_o | output | 1 | Access fault, same cycle as the request |
| irq_soft_o | output | 1 | Machine software interrupt |
| irq_timer_o | output | 1 | Machine timer interrupt |

## Verification
The assertions assume that the request fields are stable and defined whenever `req_valid_i` is high. They also assume `tick_i` is a clean synchronous level that is sampled once per clock. The stepping property further relies on the time base never passing its maximum value.

The bench changes inputs only on the falling edge, so every request sits settled across a full rising edge. It pulses the tick for single cycles with idle cycles between pulses. The time base stays far below wrap, which keeps every run inside those assumptions.

// File: rtl/core_timer_pkg.sv
`timescale 1ns/1ps
package core_timer_pkg;

    localparam int TIME_W = 64;
    localparam int HALF_W = TIME_W / 2;

    // Size code is log2 of the byte count.
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    localparam logic [15:0] OFS_SWI = 16'h0000;
    localparam logic [15:0] OFS_DEADLINE = 16'h4000;
    localparam logic [15:0] OFS_CLOCK = 16'hBFF8;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SWI,
        TGT_DL_FULL,
        TGT_DL_LO,
        TGT_DL_HI,
        TGT_CLK_FULL,
        TGT_CLK_LO,
        TGT_CLK_HI
    } target_e;

    typedef struct packed {
        logic swi_pend;
        logic [TIME_W-1:0] deadline;
    } ctu_state_t;

endpackage

// File: rtl/ctu_decode.sv
`timescale 1ns/1ps
module ctu_decode
    import core_timer_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic valid_i,
    input logic write_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [1:0] size_i,
    output target_e target_o,
    output logic fault_o
);

    localparam logic [ADDR_W-1:0] A_SWI = ADDR_W'(OFS_SWI);
    localparam logic [ADDR_W-1:0] A_DL_LO = ADDR_W'(OFS_DEADLINE);
    localparam logic [ADDR_W-1:0] A_DL_HI = ADDR_W'(OFS_DEADLINE + 16'd4);
    localparam logic [ADDR_W-1:0] A_CLK_LO = ADDR_W'(OFS_CLOCK);
    localparam logic [ADDR_W-1:0] A_CLK_HI = ADDR_W'(OFS_CLOCK + 16'd4);

    logic is_word;
    logic is_dword;

    always_comb begin
        is_word = (size_i == SZ_WORD);
        is_dword = (size_i == SZ_DWORD);
        target_o = TGT_NONE;
        if (addr_i == A_SWI && (is_word || is_dword)) begin
            target_o = TGT_SWI;
        end else if (addr_i == A_DL_LO && is_dword) begin
            target_o = TGT_DL_FULL;
        end else if (addr_i == A_DL_LO && is_word) begin
            target_o = TGT_DL_LO;
        end else if (addr_i == A_DL_HI && is_word) begin
            target_o = TGT_DL_HI;
        end else if (!write_i && addr_i == A_CLK_LO && is_dword) begin
            target_o = TGT_CLK_FULL;
        end else if (!write_i && addr_i == A_CLK_LO && is_word) begin
            target_o = TGT_CLK_LO;
        end else if (!write_i && addr_i == A_CLK_HI && is_word) begin
            target_o = TGT_CLK_HI;
        end
        fault_o = valid_i && (target_o == TGT_NONE);
    end

    // a_r5_clock_never_write_target: a write never selects the time base
    always_comb begin
        if (valid_i && write_i) begin
            a_r5_clock_never_write_target: assert (target_o != TGT_CLK_FULL &&
                target_o != TGT_CLK_LO && target_o != TGT_CLK_HI);
        end
    end

endmodule

// File: rtl/ctu_time_base.sv
`timescale 1ns/1ps
module ctu_time_base
    import core_timer_pkg::*;
#(
    parameter int TICKS_PER_INC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    output logic [TIME_W-1:0] time_o
);

    localparam int PS_W = (TICKS_PER_INC > 1) ? $clog2(TICKS_PER_INC) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICKS_PER_INC - 1);

    logic [PS_W-1:0] presc_d, presc_q;
    logic [TIME_W-1:0] time_d, time_q;

    always_comb begin
        presc_d = presc_q;
        time_d = time_q;
        if (tick_i) begin
            if (presc_q == PS_LAST) begin
                presc_d = '0;
                time_d = time_q + 1'b1;
            end else begin
                presc_d = presc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            time_q <= '0;
        end else begin
            presc_q <= presc_d;
            time_q <= time_d;
        end
    end

    assign time_o = time_q;

    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(time_o));

    a_r6_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (time_o == $past(time_o)) || (time_o == $past(time_o) + 1'b1));

endmodule

// File: rtl/core_timer_unit.sv
`timescale 1ns/1ps
module core_timer_unit
    import core_timer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TICKS_PER_INC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic req_valid_i,
    input logic req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [1:0] req_size_i,
    input logic [63:0] req_wdata_i,
    output logic [63:0] rsp_rdata_o,
    output logic rsp_fault_o,
    output logic irq_soft_o,
    output logic irq_timer_o
);

    target_e target;
    logic fault;
    logic [TIME_W-1:0] now;
    ctu_state_t st_d, st_q;

    ctu_decode #(.ADDR_W(ADDR_W)) decode_i (
        .valid_i (req_valid_i),
        .write_i (req_write_i),
        .addr_i (req_addr_i),
        .size_i (req_size_i),
        .target_o(target),
        .fault_o (fault)
    );

    ctu_time_base #(.TICKS_PER_INC(TICKS_PER_INC)) time_base_i (
        .clk (clk),
        .rst_n (rst_n),
        .tick_i(tick_i),
        .time_o(now)
    );

    always_comb begin
        st_d = st_q;
        rsp_rdata_o = '0;
        if (req_valid_i && !fault) begin
            if (req_write_i) begin
                unique case (target)
                    TGT_SWI: st_d.swi_pend = req_wdata_i[0];
                    TGT_DL_FULL: st_d.deadline = req_wdata_i;
                    TGT_DL_LO: st_d.deadline[HALF_W-1:0] = req_wdata_i[HALF_W-1:0];
                    TGT_DL_HI: st_d.deadline[TIME_W-1:HALF_W] = req_wdata_i[HALF_W-1:0];
                    default: ;
                endcase
            end else begin
                unique case (target)
                    TGT_SWI: rsp_rdata_o = {63'd0, st_q.swi_pend};
                    TGT_DL_FULL: rsp_rdata_o = st_q.deadline;
                    TGT_DL_LO: rsp_rdata_o = {32'd0, st_q.deadline[HALF_W-1:0]};
                    TGT_DL_HI: rsp_rdata_o = {32'd0, st_q.deadline[TIME_W-1:HALF_W]};
                    TGT_CLK_FULL: rsp_rdata_o = now;
                    TGT_CLK_LO: rsp_rdata_o = {32'd0, now[HALF_W-1:0]};
                    TGT_CLK_HI: rsp_rdata_o = {32'd0, now[TIME_W-1:HALF_W]};
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.swi_pend <= 1'b0;
            st_q.deadline <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_fault_o = fault;
    assign irq_soft_o = st_q.swi_pend;
    assign irq_timer_o = (now >= st_q.deadline);

    a_r2_swi_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && target == TGT_SWI)
        |=> irq_soft_o == $past(req_wdata_i[0]));

    a_r3_swi_read_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && target == TGT_SWI)
        |-> rsp_rdata_o[63:1] == '0);

    a_r4_full_deadline_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && target == TGT_DL_FULL)
        |=> st_q.deadline == $past(req_wdata_i));

    a_r8_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && rsp_fault_o)
        |=> $stable(irq_soft_o) && $stable(st_q.deadline));

    a_r8_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_o |-> rsp_rdata_o == '0);

endmodule

// File: tb/core_timer_unit_tb_top.sv
`timescale 1ns/1ps
module core_timer_unit_tb_top;

    localparam int TPI = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic valid = 1'b0;
    logic wr = 1'b0;
    logic [15:0] addr = '0;
    logic [1:0] size = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic fault;
    logic irq_s;
    logic irq_t;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    core_timer_unit #(.ADDR_W(16), .TICKS_PER_INC(TPI)) dut_i (
        .clk (clk),
        .rst_n (rst_n),
        .tick_i (tick),
        .req_valid_i(valid),
        .req_write_i(wr),
        .req_addr_i (addr),
        .req_size_i (size),
        .req_wdata_i(wdata),
        .rsp_rdata_o(rdata),
        .rsp_fault_o(fault),
        .irq_soft_o (irq_s),
        .irq_timer_o(irq_t)
    );

    typedef struct packed {
        logic [3:0] req;
        logic wr;
        logic [15:0] addr;
        logic [1:0] size;
        logic [63:0] wdata;
        logic fault;
        logic [63:0] rdata;
    } vec_t;

    // Time base stays at 0 through the table (no ticks).
    localparam vec_t VECS [17] = '{
        '{4'd3, 1'b0, 16'h0000, 2'd3, 64'd0, 1'b0, 64'd0},                      // R3 read clear bit
        '{4'd2, 1'b1, 16'h0000, 2'd2, 64'hFFFF_FFFF_FFFF_FFF1, 1'b0, 64'd0},   // R2 set via 4B
        '{4'd3, 1'b0, 16'h0000, 2'd2, 64'd0, 1'b0, 64'd1},                      // R3
        '{4'd8, 1'b0, 16'h0000, 2'd1, 64'd0, 1'b1, 64'd0},                      // R8 2B size
        '{4'd4, 1'b1, 16'h4000, 2'd3, 64'h0000_0010_0000_0020, 1'b0, 64'd0},   // R4
        '{4'd4, 1'b0, 16'h4000, 2'd3, 64'd0, 1'b0, 64'h0000_0010_0000_0020},   // R4
        '{4'd4, 1'b0, 16'h4004, 2'd2, 64'd0, 1'b0, 64'h10},                     // R4 upper half
        '{4'd4, 1'b1, 16'h4004, 2'd2, 64'hDEAD_0000_0000_00AA, 1'b0, 64'd0},   // R4
        '{4'd4, 1'b0, 16'h4000, 2'd3, 64'd0, 1'b0, 64'h0000_00AA_0000_0020},   // R4
        '{4'd8, 1'b1, 16'h4004, 2'd3, 64'h1234, 1'b1, 64'd0},                   // R8 8B at +4
        '{4'd8, 1'b0, 16'h4000, 2'd3, 64'd0, 1'b0, 64'h0000_00AA_0000_0020},   // R8 unchanged
        '{4'd5, 1'b1, 16'hBFF8, 2'd3, 64'h55, 1'b1, 64'd0},                     // R5 write faults
        '{4'd5, 1'b0, 16'hBFF8, 2'd3, 64'd0, 1'b0, 64'd0},                      // R5
        '{4'd8, 1'b1, 16'h0008, 2'd2, 64'd0, 1'b1, 64'd0},                      // R8 other offset
        '{4'd8, 1'b0, 16'h0000, 2'd3, 64'd0, 1'b0, 64'd1},                      // R8 bit kept
        '{4'd2, 1'b1, 16'h0000, 2'd3, 64'd2, 1'b0, 64'd0},                      // R2 bit0=0 clears
        '{4'd3, 1'b0, 16'h0000, 2'd3, 64'd0, 1'b0, 64'd0}                       // R3
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [15:0] a, input logic [1:0] s,
                          input logic [63:0] d, output logic f, output logic [63:0] r);
        @(negedge clk);
        valid = 1'b1;
        wr = w;
        addr = a;
        size = s;
        wdata = d;
        #5;
        f = fault;
        r = rdata;
        @(negedge clk);
        valid = 1'b0;
        wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        logic f;
        logic [63:0] r;
        #95;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(irq_s == 1'b0, "R1 irq_soft", {63'd0, irq_s}, 64'd0);
        check(irq_t == 1'b0, "R1 irq_timer", {63'd0, irq_t}, 64'd0);
        access(1'b0, 16'h4000, 2'd3, 64'd0, f, r);
        check(r == '1 && !f, "R1 deadline", r, '1);
        access(1'b0, 16'hBFF8, 2'd3, 64'd0, f, r);
        check(r == 64'd0 && !f, "R1 time", r, 64'd0);

        for (int i = 0; i < 17; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, f, r);
            check(f == VECS[i].fault, $sformatf("R%0d fault v%0d", VECS[i].req, i),
                  {63'd0, f}, {63'd0, VECS[i].fault});
            check(r == VECS[i].rdata, $sformatf("R%0d data v%0d", VECS[i].req, i),
                  r, VECS[i].rdata);
            if (i == 1) check(irq_s == 1'b1, "R2 irq_soft set", {63'd0, irq_s}, 64'd1);
            if (i == 15) check(irq_s == 1'b0, "R2 irq_soft clear", {63'd0, irq_s}, 64'd0);
        end

        // R8 1-byte size on deadline faults
        access(1'b1, 16'h4000, 2'd0, 64'd7, f, r);
        check(f == 1'b1, "R8 1B fault", {63'd0, f}, 64'd1);

        // R6 / R7 time base and timer interrupt
        access(1'b1, 16'h4000, 2'd3, 64'd3, f, r);
        ticks(3 * TPI - 1);
        access(1'b0, 16'hBFF8, 2'd3, 64'd0, f, r);
        check(r == 64'd2, "R6 time after 11 ticks", r, 64'd2);
        check(irq_t == 1'b0, "R7 timer low below deadline", {63'd0, irq_t}, 64'd0);
        repeat (5) @(negedge clk);
        access(1'b0, 16'hBFF8, 2'd2, 64'd0, f, r);
        check(r == 64'd2, "R6 idle cycles do not count", r, 64'd2);
        ticks(1);
        check(irq_t == 1'b1, "R7 timer high at deadline", {63'd0, irq_t}, 64'd1);
        access(1'b0, 16'hBFF8, 2'd2, 64'd0, f, r);
        check(r == 64'd3, "R5 time low half", r, 64'd3);
        access(1'b0, 16'hBFFC, 2'd2, 64'd0, f, r);
        check(r == 64'd0 && !f, "R5 time high half", r, 64'd0);
        access(1'b1, 16'h4000, 2'd3, 64'd100, f, r);
        check(irq_t == 1'b0, "R7 larger deadline clears", {63'd0, irq_t}, 64'd0);
        access(1'b1, 16'h4000, 2'd2, 64'hFFFF_FFFF_0000_0002, f, r);
        check(irq_t == 1'b1, "R4 low half write, R7 rise", {63'd0, irq_t}, 64'd1);
        access(1'b1, 16'hBFFC, 2'd3, 64'd0, f, r);
        check(f == 1'b1, "R8 8B at time upper", {63'd0, f}, 64'd1);

        summary();
        done = 1'b1;
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule